// File: doc/BRIEF.md
# Bit-Field and Count Unit

A purely combinational 32-bit datapath slice for bit manipulation inside an integer execution stage. It counts leading zeros or leading ones and swaps the two bytes inside each halfword. It sign-extends the low byte or the low halfword, pulls a bit field out of a word, deposits a bit field into a word, and places an immediate in the upper half of a word.

Each operation takes a 4-bit opcode, two data operands (`src_s_i`, `src_t_i`), a 5-bit position and a 5-bit size field. The size field encodes the field width minus one. The result appears in the same cycle. An opcode outside the defined set yields zero and raises a flag that the surrounding pipeline can turn into an illegal-instruction event.

Top module: `bfc_unit`

## Requirements
- R1: Opcode 0 returns the number of leading zero bits of `src_s_i`, zero-extended to 32 bits; an all-zero operand gives 32.
- R2: Opcode 1 returns the number of leading one bits of `src_s_i`; an all-ones operand gives 32.
- R3: Opcode 2 swaps the two bytes within each halfword of `src_t_i` (bits 15:8 trade places with 7:0, and 31:24 with 23:16).
- R4: Opcode 3 returns `src_t_i[7:0]` with bit 7 copied into bits 31:8.
- R5: Opcode 4 returns `src_t_i[15:0]` with bit 15 copied into bits 31:16.
- R6: Opcode 5 returns bits of `src_s_i` starting at bit `pos_i`, keeping `size_i`+1 low bits and zeroing the rest; source bits above bit 31 read as zero.
- R7: Opcode 6 writes the low `size_i`+1 bits of `src_s_i` into `src_t_i` starting at bit `pos_i`; all other bits of `src_t_i` pass unchanged, and field bits above bit 31 are dropped.
- R8: With `size_i` = 31 the field covers the full word: extract at position 0 returns `src_s_i` unchanged, and insert at position 0 returns `src_s_i`.
- R9: Opcode 7 returns `src_t_i` shifted left by 16 with the low 16 bits zero.
- R10: Opcodes 8 to 15 return zero with `illegal_o` = 1; opcodes 0 to 7 hold `illegal_o` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation select |
| src_s_i | input | 32 | First data operand (count source, field source) |
| src_t_i | input | 32 | Second data operand (lane source, insert target) |
| pos_i | input | 5 | Field start bit |
| size_i | input | 5 | Field width minus one |
| res_o | output | 32 | Result |
| illegal_o | output | 1 | Opcode outside the defined set |

## Verification
The cases hardest to reach are the field operations whose window runs past bit 31. The full-width mask case also needs care, because there the size field plus one equals the word width and a naive mask shift would wrap. Random 32-bit operands almost never produce long runs of leading zeros or ones, so each count stage's half-window test rarely fires on random data. The stimulus therefore sweeps a single set bit, and a single clear bit, across every position. It walks position and size through their extremes with directed values, and it draws random operands through a random right-shift so that every count value appears.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  parameter int DATA_W = 32;
  parameter int POS_W  = $clog2(DATA_W);
  parameter int OP_W   = 4;
  parameter int CNT_W  = $clog2(DATA_W) + 1;
  parameter int UP_SH  = 16;

  typedef enum logic [OP_W-1:0] {
    OP_CLZ  = 4'd0,
    OP_CLO  = 4'd1,
    OP_BSWH = 4'd2,
    OP_SXB  = 4'd3,
    OP_SXH  = 4'd4,
    OP_EXT  = 4'd5,
    OP_INS  = 4'd6,
    OP_UPI  = 4'd7
  } bfc_op_e;
endpackage

// File: rtl/bfc_lzc.sv
module bfc_lzc #(
  parameter int W  = 32,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  a_i,
  output logic [CW-1:0] cnt_o
);
  localparam int STG = $clog2(W) - 2;

  logic [STG-1:0] z;
  logic [3:0]     nib;
  logic [1:0]     lz2;

  for (genvar g = 0; g < STG; g++) begin : stg
    localparam int H = W >> (g + 1);
    logic [2*H-1:0] win;
    logic [H-1:0]   nxt;
    if (g == 0) begin : g_first
      assign win = a_i;
    end else begin : g_rest
      assign win = stg[g-1].nxt;
    end
    assign z[g] = ~|win[2*H-1:H];
    assign nxt  = z[g] ? win[H-1:0] : win[2*H-1:H];
  end

  assign nib = stg[STG-1].nxt;

  always_comb begin
    casez (nib)
      4'b1???: lz2 = 2'd0;
      4'b01??: lz2 = 2'd1;
      4'b001?: lz2 = 2'd2;
      default: lz2 = 2'd3;
    endcase
  end

  always_comb begin
    cnt_o = '0;
    if (nib == 4'd0) begin
      cnt_o = CW'(W);
    end else begin
      for (int g = 0; g < STG; g++) cnt_o[CW-2-g] = z[g];
      cnt_o[1:0] = lz2;
    end
  end
endmodule

// File: rtl/bfc_field.sv
module bfc_field #(
  parameter int W  = 32,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  s_i,
  input  logic [W-1:0]  t_i,
  input  logic [PW-1:0] pos_i,
  input  logic [PW-1:0] size_i,
  output logic [W-1:0]  ext_o,
  output logic [W-1:0]  ins_o
);
  logic [W-1:0] mask;
  logic [W-1:0] pmask;

  // two-step shift keeps size = W-1 from wrapping
  assign mask  = ~(({W{1'b1}} << size_i) << 1);
  assign pmask = mask << pos_i;
  assign ext_o = (s_i >> pos_i) & mask;
  assign ins_o = ((s_i & mask) << pos_i) | (t_i & ~pmask);
endmodule

// File: rtl/bfc_lane.sv
module bfc_lane #(
  parameter int W  = 32,
  parameter int SH = 16
) (
  input  logic [W-1:0] t_i,
  output logic [W-1:0] bswh_o,
  output logic [W-1:0] sxb_o,
  output logic [W-1:0] sxh_o,
  output logic [W-1:0] upi_o
);
  localparam int NH = W / 16;

  for (genvar h = 0; h < NH; h++) begin : hw
    assign bswh_o[16*h+15 -: 8] = t_i[16*h+7  -: 8];
    assign bswh_o[16*h+7  -: 8] = t_i[16*h+15 -: 8];
  end

  assign sxb_o = {{(W-8){t_i[7]}}, t_i[7:0]};
  assign sxh_o = {{(W-16){t_i[15]}}, t_i[15:0]};
  assign upi_o = t_i << SH;
endmodule

// File: rtl/bfc_unit.sv
module bfc_unit
  import bfc_pkg::*;
(
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] src_s_i,
  input  logic [DATA_W-1:0] src_t_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [POS_W-1:0]  size_i,
  output logic [DATA_W-1:0] res_o,
  output logic              illegal_o
);
  logic              clo_sel;
  logic [DATA_W-1:0] cnt_src;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] ext_v, ins_v, bswh_v, sxb_v, sxh_v, upi_v;

  // one shared counter: ones are counted as zeros of the inverse
  assign clo_sel = (op_i == OP_CLO);
  assign cnt_src = clo_sel ? ~src_s_i : src_s_i;

  bfc_lzc #(.W(DATA_W), .CW(CNT_W)) u_lzc (
    .a_i   (cnt_src),
    .cnt_o (cnt)
  );

  bfc_field #(.W(DATA_W), .PW(POS_W)) u_field (
    .s_i    (src_s_i),
    .t_i    (src_t_i),
    .pos_i  (pos_i),
    .size_i (size_i),
    .ext_o  (ext_v),
    .ins_o  (ins_v)
  );

  bfc_lane #(.W(DATA_W), .SH(UP_SH)) u_lane (
    .t_i    (src_t_i),
    .bswh_o (bswh_v),
    .sxb_o  (sxb_v),
    .sxh_o  (sxh_v),
    .upi_o  (upi_v)
  );

  always_comb begin
    res_o     = '0;
    illegal_o = 1'b0;
    case (op_i)
      OP_CLZ, OP_CLO: res_o = DATA_W'(cnt);
      OP_BSWH:        res_o = bswh_v;
      OP_SXB:         res_o = sxb_v;
      OP_SXH:         res_o = sxh_v;
      OP_EXT:         res_o = ext_v;
      OP_INS:         res_o = ins_v;
      OP_UPI:         res_o = upi_v;
      default:        illegal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/bfc_unit_chk.sv
module bfc_unit_chk
  import bfc_pkg::*;
(
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] src_s_i,
  input logic [DATA_W-1:0] src_t_i,
  input logic [POS_W-1:0]  pos_i,
  input logic [POS_W-1:0]  size_i,
  input logic [DATA_W-1:0] res_o,
  input logic              illegal_o
);
  always_comb begin
    if (!$isunknown(op_i) && !$isunknown(res_o)) begin
      // R1
      clz_range_chk: assert (op_i != 4'd0 || (res_o <= DATA_W && ((res_o == DATA_W) == (src_s_i == '0))));
      // R2
      clo_range_chk: assert (op_i != 4'd1 || (res_o <= DATA_W && ((res_o == DATA_W) == (src_s_i == '1))));
      // R4
      sxb_fill_chk: assert (op_i != 4'd3 || (res_o[7:0] == src_t_i[7:0] && res_o[DATA_W-1:8] == {(DATA_W-8){src_t_i[7]}}));
      // R8
      full_field_chk: assert (!((op_i == 4'd5 || op_i == 4'd6) && pos_i == '0 && size_i == '1) || res_o == src_s_i);
      // R9
      upi_low_chk: assert (op_i != 4'd7 || res_o[15:0] == 16'd0);
      // R10
      illegal_flag_chk: assert (illegal_o == op_i[3]);
      // R10
      illegal_zero_chk: assert (!illegal_o || res_o == '0);
    end
  end
endmodule

bind bfc_unit bfc_unit_chk u_chk (
  .op_i      (op_i),
  .src_s_i   (src_s_i),
  .src_t_i   (src_t_i),
  .pos_i     (pos_i),
  .size_i    (size_i),
  .res_o     (res_o),
  .illegal_o (illegal_o)
);

// File: tb/tb_bfc_unit.sv
module tb_bfc_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 150000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op;
  logic [31:0] s, t;
  logic [4:0]  pos, size;
  logic [31:0] res;
  logic        ill;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bfc_unit dut (
    .op_i(op), .src_s_i(s), .src_t_i(t), .pos_i(pos), .size_i(size),
    .res_o(res), .illegal_o(ill)
  );

  function automatic logic [31:0] ref_clz(input logic [31:0] a);
    int n = 0;
    for (int i = 31; i >= 0; i--) begin
      if (a[i]) break;
      n++;
    end
    return 32'(n);
  endfunction

  function automatic logic [31:0] ref_op(input logic [3:0] o, input logic [31:0] a,
                                         input logic [31:0] b, input logic [4:0] p,
                                         input logic [4:0] z);
    logic [31:0] r = 32'd0;
    case (o)
      4'd0: r = ref_clz(a);
      4'd1: r = ref_clz(~a);
      4'd2: r = {b[23:16], b[31:24], b[7:0], b[15:8]};
      4'd3: for (int i = 0; i < 32; i++) r[i] = (i < 8) ? b[i] : b[7];
      4'd4: for (int i = 0; i < 32; i++) r[i] = (i < 16) ? b[i] : b[15];
      4'd5: for (int i = 0; i <= int'(z); i++) if (int'(p) + i < 32) r[i] = a[int'(p) + i];
      4'd6: begin
        r = b;
        for (int i = 0; i <= int'(z); i++) if (int'(p) + i < 32) r[int'(p) + i] = a[i];
      end
      4'd7: for (int i = 16; i < 32; i++) r[i] = b[i-16];
      default: r = 32'd0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [3:0] o, input logic [4:0] p, input logic [4:0] z);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return (p == 0 && z == 31) ? "R8" : "R6";
      4'd6: return (p == 0 && z == 31) ? "R8" : "R7";
      4'd7: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] p, input logic [4:0] z);
    logic [31:0] exp_r;
    logic        exp_i;
    string       tg;
    @(negedge clk);
    op = o; s = a; t = b; pos = p; size = z;
    @(posedge clk);
    #1;
    exp_r = ref_op(o, a, b, p, z);
    exp_i = (o >= 4'd8);
    tg    = tag_of(o, p, z);
    n_chk++;
    if (res !== exp_r) begin
      n_err++;
      $display("FAIL %s op=%0d s=%h t=%h pos=%0d size=%0d: res=%h expected %h", tg, o, a, b, p, z, res, exp_r);
    end
    n_chk++;
    if (ill !== exp_i) begin
      n_err++;
      $display("FAIL R10 op=%0d: illegal=%0b expected %0b", o, ill, exp_i);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG_CYC) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired: cycles=%0d expected < %0d", cyc, WDOG_CYC);
      finish_run();
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_1234);
    op = 4'd0; s = '0; t = '0; pos = '0; size = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset-time state: zero operand, clz opcode -> 32 (R1)
    apply(4'd0, 32'd0, 32'd0, 5'd0, 5'd0);
    // R1 R2: walking set bit / clear bit
    for (int i = 0; i < 32; i++) begin
      apply(4'd0, 32'h1 << i, 32'd0, 5'd0, 5'd0);
      apply(4'd0, 32'hFFFF_FFFF >> i, 32'd0, 5'd0, 5'd0);
      apply(4'd1, ~(32'h1 << i), 32'd0, 5'd0, 5'd0);
      apply(4'd1, ~(32'hFFFF_FFFF >> i), 32'd0, 5'd0, 5'd0);
    end
    apply(4'd1, 32'hFFFF_FFFF, 32'd0, 5'd0, 5'd0);
    apply(4'd1, 32'd0, 32'd0, 5'd0, 5'd0);
    // R3 R4 R5 R9: sign-boundary patterns
    apply(4'd2, 32'd0, 32'h1122_3344, 5'd0, 5'd0);
    apply(4'd3, 32'd0, 32'h0000_0080, 5'd0, 5'd0);
    apply(4'd3, 32'd0, 32'hFFFF_FF7F, 5'd0, 5'd0);
    apply(4'd4, 32'd0, 32'h0000_8000, 5'd0, 5'd0);
    apply(4'd4, 32'd0, 32'hFFFF_7FFF, 5'd0, 5'd0);
    apply(4'd7, 32'd0, 32'hABCD_1234, 5'd0, 5'd0);
    // R6 R7 R8: position/size extremes
    for (int p = 0; p < 32; p += 31) begin
      for (int z = 0; z < 32; z += 31) begin
        apply(4'd5, 32'hDEAD_BEEF, 32'h1234_5678, 5'(p), 5'(z));
        apply(4'd6, 32'hDEAD_BEEF, 32'h1234_5678, 5'(p), 5'(z));
      end
    end
    apply(4'd5, 32'hC3A5_0F96, 32'd0, 5'd0, 5'd31);
    apply(4'd6, 32'hC3A5_0F96, 32'h0F0F_0F0F, 5'd0, 5'd31);
    apply(4'd6, 32'hFFFF_FFFF, 32'd0, 5'd28, 5'd7);
    apply(4'd5, 32'h8000_0001, 32'd0, 5'd20, 5'd15);
    // R10: every undefined opcode
    for (int o = 8; o < 16; o++) apply(4'(o), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31, 5'd31);
    // random mix, count sources shifted so all counts appear
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] a;
      a = $urandom >> ($urandom % 33);
      if ($urandom % 2) a = ~a;
      apply(4'($urandom % 16), a, $urandom, 5'($urandom), 5'($urandom));
    end
    finish_run();
  end
endmodule